// File: doc/BRIEF.md
# SPI Client Receiver with Address Filter

This block is the peripheral side of an SPI link running in clock mode 0. The serial lines (clock, data in, select) are brought into the system clock domain through synchronizer chains. Received bits are taken on rising serial-clock edges and transmit bits change on falling edges, most significant bit first. Characters are 8 or 9 bits wide.

When address filtering is on, the first character after the select line falls is treated as an address. That address is compared against two programmed values using one of three rules. If the rule fails, the data characters of that select period are ignored. Accepted characters land in a one-entry receive buffer, which has a sticky overflow flag.

On the transmit side, a holding register feeds the shift register at the start of each character. The block can also preload the shift register directly while select is high. The receiver enable clears the buffer and overflow state immediately, and raises a busy flag while enabling. An optional detector pulses on every falling edge of select.

Top module: `spi_client`

## Requirements
- R1: After reset, rx_valid, rx_ovf, rx_busy and wake are 0 and miso is 1.
- R2: A character is char_sz==1 → 9 bits, any other char_sz value → 8 bits. It is received MSB first on rising sck and presented right-aligned on rx_data, with bit 8 zero in 8-bit mode.
- R3: With addr_en=1, the first character after ss_n falls is an address and is never stored. Its low 8 bits a are compared against addr_val (A) and mask_val (M) according to amode. amode 0 matches when (a^A)&~M is zero. amode 1 matches when a==A or a==M. amode 2 matches when M<=a<=A. amode 3 never matches. Later characters in the same select period are stored only on a match.
- R4: With addr_en=0, every complete character is stored.
- R5: A character that completes while rx_valid=1 and rd_strobe is low is dropped. rx_data keeps the older value, and rx_ovf is set and stays set while rx_en=1.
- R6: rx_en=0 clears rx_valid and rx_ovf at the next clock edge and discards any partly received character.
- R7: When rx_en rises, rx_busy is 1 at once and returns to 0 within three clock cycles while rx_en stays 1.
- R8: With preload_en=1 and ss_n high, a wr_en write is copied directly into the transmit shift register. That value is the next character on miso.
- R9: Without preload, written data waits in a holding register and is loaded at the first rising sck of a character. If nothing is pending, the character is all ones.
- R10: ss_n going high in mid-character discards the partial character, and the next select period starts from bit zero.
- R11: With ss_wake_en=1, each falling edge of ss_n gives a wake pulse of exactly one cycle. With ss_wake_en=0, wake stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable |
| addr_en | input | 1 | First character of each select period is an address |
| amode | input | 2 | Address rule: 0 masked, 1 two exact, 2 range, 3 none |
| addr_val | input | 8 | Address value / range upper bound |
| mask_val | input | 8 | Mask, second address or range lower bound |
| preload_en | input | 1 | Allow direct shift-register load while ss_n high |
| ss_wake_en | input | 1 | Enable select-fall wake pulse |
| char_sz | input | 3 | Character size code |
| wr_en | input | 1 | Transmit data write strobe |
| wr_data | input | 9 | Transmit data |
| rd_strobe | input | 1 | Pop the receive buffer |
| sck | input | 1 | Serial clock from host |
| mosi | input | 1 | Serial data from host |
| ss_n | input | 1 | Active-low select from host |
| miso | output | 1 | Serial data to host |
| rx_valid | output | 1 | Receive buffer holds a character |
| rx_data | output | 9 | Receive buffer contents |
| rx_ovf | output | 1 | Receive overflow flag |
| rx_busy | output | 1 | Receiver is being enabled |
| wake | output | 1 | Select-fall wake pulse |

## Verification
The hardest condition to reach is an address that sits exactly on a filter boundary: a masked bit that differs, the lower or upper end of the range, or one of the two exact addresses. Each of these is followed by a data character whose acceptance is the only visible result. The bench reaches it with a sweep of all 64 addresses in a small window around the programmed values, for each of the four rules. Each sweep step sends an address character and then a data character under a fresh select period. The received buffer state is compared against a match computed arithmetically from the rule.

// File: rtl/spi_cl_pkg.sv
package spi_cl_pkg;

    localparam int DATA_W = 9;
    localparam int ADDR_W = 8;
    localparam int CNT_W  = $clog2(DATA_W + 1);

    typedef enum logic [1:0] {
        AM_MASKED = 2'd0,
        AM_PAIR   = 2'd1,
        AM_RANGE  = 2'd2,
        AM_NONE   = 2'd3
    } amode_e;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    function automatic logic [CNT_W-1:0] char_len(input logic [2:0] code);
        return (code == 3'd1) ? CNT_W'(9) : CNT_W'(8);
    endfunction

    function automatic logic addr_hit(input amode_e m, input addr_t a,
                                      input addr_t hi, input addr_t lo);
        case (m)
            AM_MASKED: return ((a ^ hi) & ~lo) == '0;
            AM_PAIR:   return (a == hi) || (a == lo);
            AM_RANGE:  return (a >= lo) && (a <= hi);
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/spi_cl_sync.sv
module spi_cl_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{RST_VAL[g]}};
            else     chain <= {chain[STAGES-2:0], d[g]};
        end
        assign q[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/spi_cl_addr_filter.sv
module spi_cl_addr_filter
    import spi_cl_pkg::*;
(
    input  amode_e mode,
    input  addr_t  rx_addr,
    input  addr_t  hi_val,
    input  addr_t  lo_val,
    output logic   hit
);
    assign hit = addr_hit(mode, rx_addr, hi_val, lo_val);
endmodule

// File: rtl/spi_cl_tx.sv
module spi_cl_tx
    import spi_cl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ss_hi,
    input  logic             sck_rise,
    input  logic             sck_fall,
    input  logic [CNT_W-1:0] len,
    input  logic             preload_en,
    input  logic             wr_en,
    input  word_t            wr_data,
    output logic             miso
);
    word_t            sh, hold;
    logic             pend, loaded;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '1;
            hold   <= '0;
            pend   <= 1'b0;
            loaded <= 1'b0;
            cnt    <= '0;
        end else begin
            if (ss_hi) begin
                cnt <= '0;
            end else if (sck_rise) begin
                cnt <= (cnt == len - 1'b1) ? '0 : cnt + 1'b1;
                if (cnt == '0) begin
                    if (loaded)    loaded <= 1'b0;
                    else if (pend) begin
                        sh   <= hold;
                        pend <= 1'b0;
                    end else       sh <= '1;
                end
            end else if (sck_fall) begin
                sh <= {sh[DATA_W-2:0], 1'b1};
            end
            if (wr_en) begin
                if (preload_en && ss_hi) begin
                    sh     <= wr_data;
                    loaded <= 1'b1;
                end else begin
                    hold <= wr_data;
                    pend <= 1'b1;
                end
            end
        end
    end

    assign miso = ss_hi ? 1'b1 : ((len == CNT_W'(9)) ? sh[8] : sh[7]);
endmodule

// File: rtl/spi_client.sv
module spi_client
    import spi_cl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_en,
    input  logic               addr_en,
    input  logic [1:0]         amode,
    input  logic [ADDR_W-1:0]  addr_val,
    input  logic [ADDR_W-1:0]  mask_val,
    input  logic               preload_en,
    input  logic               ss_wake_en,
    input  logic [2:0]         char_sz,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               rd_strobe,
    input  logic               sck,
    input  logic               mosi,
    input  logic               ss_n,
    output logic               miso,
    output logic               rx_valid,
    output logic [DATA_W-1:0]  rx_data,
    output logic               rx_ovf,
    output logic               rx_busy,
    output logic               wake
);
    logic sck_s, mosi_s, ss_s;
    logic sck_q, ss_q;
    logic sck_rise, sck_fall, ss_fall;

    spi_cl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ss_n, sck, mosi}),
        .q   ({ss_s, sck_s, mosi_s})
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            ss_q  <= 1'b1;
        end else begin
            sck_q <= sck_s;
            ss_q  <= ss_s;
        end
    end

    assign sck_rise = sck_s & ~sck_q & ~ss_s;
    assign sck_fall = ~sck_s & sck_q & ~ss_s;
    assign ss_fall  = ~ss_s & ss_q;

    logic [CNT_W-1:0] len;
    assign len = char_len(char_sz);

    // receiver enable sequencing
    logic en_d1, rx_on, rx_act;
    assign rx_act  = rx_en & rx_on;
    assign rx_busy = rx_en & ~rx_on;

    // receive path
    word_t            rx_sh, buf_q, nxt_word;
    logic [CNT_W-1:0] rx_cnt;
    logic             first_seen, addr_ok, buf_v, ovf_q, wake_q, hit;

    assign nxt_word = (len == CNT_W'(9)) ? {rx_sh[DATA_W-2:0], mosi_s}
                                         : {1'b0, rx_sh[DATA_W-3:0], mosi_s};

    spi_cl_addr_filter u_filt (
        .mode    (amode_e'(amode)),
        .rx_addr (nxt_word[ADDR_W-1:0]),
        .hi_val  (addr_val),
        .lo_val  (mask_val),
        .hit     (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_d1      <= 1'b0;
            rx_on      <= 1'b0;
            rx_sh      <= '0;
            rx_cnt     <= '0;
            first_seen <= 1'b0;
            addr_ok    <= 1'b0;
            buf_q      <= '0;
            buf_v      <= 1'b0;
            ovf_q      <= 1'b0;
            wake_q     <= 1'b0;
        end else begin
            en_d1  <= rx_en;
            rx_on  <= rx_en & en_d1;
            wake_q <= ss_wake_en & ss_fall;
            if (rd_strobe && buf_v) buf_v <= 1'b0;
            if (ss_s) begin
                rx_cnt     <= '0;
                first_seen <= 1'b0;
                addr_ok    <= 1'b0;
            end else if (!rx_act) begin
                rx_cnt <= '0;
            end else if (sck_rise) begin
                rx_sh <= nxt_word;
                if (rx_cnt == len - 1'b1) begin
                    rx_cnt <= '0;
                    if (addr_en && !first_seen) begin
                        first_seen <= 1'b1;
                        addr_ok    <= hit;
                    end else if (!addr_en || addr_ok) begin
                        if (buf_v && !rd_strobe) begin
                            ovf_q <= 1'b1;
                        end else begin
                            buf_q <= nxt_word;
                            buf_v <= 1'b1;
                        end
                    end
                end else begin
                    rx_cnt <= rx_cnt + 1'b1;
                end
            end
            if (!rx_en) begin
                buf_v <= 1'b0;
                ovf_q <= 1'b0;
            end
        end
    end

    spi_cl_tx u_tx (
        .clk        (clk),
        .rst        (rst),
        .ss_hi      (ss_s),
        .sck_rise   (sck_rise),
        .sck_fall   (sck_fall),
        .len        (len),
        .preload_en (preload_en),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .miso       (miso)
    );

    assign rx_valid = buf_v;
    assign rx_data  = buf_q;
    assign rx_ovf   = ovf_q;
    assign wake     = wake_q;
endmodule

// File: rtl/spi_client_chk.sv
module spi_client_chk
    import spi_cl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rx_en,
    input logic              ss_wake_en,
    input logic              rd_strobe,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_ovf,
    input logic              rx_busy,
    input logic              wake
);
    a_r6_flush: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (!rx_valid && !rx_ovf));

    a_r7_busy_on_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_en) |-> rx_busy);

    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (rx_ovf && rx_en) |=> (rx_ovf || !rx_en));

    a_r5_keep_data: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_en && !rd_strobe) |=> (!rx_en || (rx_valid && $stable(rx_data))));

    a_r11_one_cycle: assert property (@(posedge clk) disable iff (rst)
        wake |=> !wake);

    a_r11_gated: assert property (@(posedge clk) disable iff (rst)
        wake |-> $past(ss_wake_en));
endmodule

bind spi_client spi_client_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_en      (rx_en),
    .ss_wake_en (ss_wake_en),
    .rd_strobe  (rd_strobe),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_ovf     (rx_ovf),
    .rx_busy    (rx_busy),
    .wake       (wake)
);

// File: tb/spi_client_bench.sv
module spi_client_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_en = 1'b0, addr_en = 1'b0, preload_en = 1'b0, ss_wake_en = 1'b0;
    logic [1:0] amode = 2'd0;
    logic [7:0] addr_val = '0, mask_val = '0;
    logic [2:0] char_sz = 3'd0;
    logic       wr_en = 1'b0, rd_strobe = 1'b0;
    logic [8:0] wr_data = '0;
    logic       sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
    logic       miso, rx_valid, rx_ovf, rx_busy, wake;
    logic [8:0] rx_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    spi_client u_spi_client (
        .clk(clk), .rst(rst), .rx_en(rx_en), .addr_en(addr_en), .amode(amode),
        .addr_val(addr_val), .mask_val(mask_val), .preload_en(preload_en),
        .ss_wake_en(ss_wake_en), .char_sz(char_sz), .wr_en(wr_en), .wr_data(wr_data),
        .rd_strobe(rd_strobe), .sck(sck), .mosi(mosi), .ss_n(ss_n), .miso(miso),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ovf(rx_ovf), .rx_busy(rx_busy),
        .wake(wake)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift(input logic [8:0] d, input int n, output logic [8:0] got);
        got = '1;
        for (int i = n - 1; i >= 0; i--) begin
            mosi = d[i];
            wclk(4);
            sck = 1'b1;
            wclk(4);
            got[i] = miso;
            sck = 1'b0;
        end
        wclk(4);
    endtask

    task automatic sel(input logic lvl);
        ss_n = lvl;
        wclk(6);
    endtask

    task automatic write_tx(input logic [8:0] d);
        wr_data = d;
        wr_en = 1'b1;
        wclk(1);
        wr_en = 1'b0;
    endtask

    task automatic pop();
        rd_strobe = 1'b1;
        wclk(1);
        rd_strobe = 1'b0;
    endtask

    function automatic bit exp_hit(input int m, input int a, input int hi, input int lo);
        case (m)
            0: return ((a ^ hi) & (~lo) & 8'hFF) == 0;
            1: return (a == hi) || (a == lo);
            2: return (a >= lo) && (a <= hi);
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [8:0] got;
        int hi_t[4];
        int lo_t[4];
        hi_t = '{8'h25, 8'h30, 8'h28, 8'h05};
        lo_t = '{8'h0C, 8'h07, 8'h10, 8'h05};
        wclk(3);
        rst = 1'b0;
        wclk(1);
        // R1 reset state
        chk("R1 rx_valid", rx_valid, 0);
        chk("R1 rx_ovf", rx_ovf, 0);
        chk("R1 rx_busy", rx_busy, 0);
        chk("R1 wake", wake, 0);
        chk("R1 miso", miso, 1);

        // R7 busy on enable
        rx_en = 1'b1;
        #1;
        chk("R7 busy set", rx_busy, 1);
        wclk(3);
        chk("R7 busy clear", rx_busy, 0);

        // R3 address filter sweep
        addr_en = 1'b1;
        for (int m = 0; m < 4; m++) begin
            amode = 2'(m);
            addr_val = 8'(hi_t[m]);
            mask_val = 8'(lo_t[m]);
            for (int a = 0; a < 64; a++) begin
                bit e;
                e = exp_hit(m, a, hi_t[m], lo_t[m]);
                sel(1'b0);
                shift(9'(a), 8, got);
                shift(9'(a ^ 8'h5A), 8, got);
                sel(1'b1);
                chk($sformatf("R3 mode%0d addr %0h valid", m, a), rx_valid, int'(e));
                if (e) chk("R3 data", rx_data, (a ^ 8'h5A));
                pop();
            end
        end
        addr_en = 1'b0;

        // R2 9-bit with R9 pending load
        char_sz = 3'd1;
        write_tx(9'h1A5);
        sel(1'b0);
        shift(9'h13C, 9, got);
        sel(1'b1);
        chk("R2 9-bit rx", rx_data, 9'h13C);
        chk("R9 9-bit tx", got, 9'h1A5);
        pop();

        // R2 reserved size -> 8 bits, R4 no addressing, R9 all ones
        char_sz = 3'd5;
        sel(1'b0);
        shift(9'h0C3, 8, got);
        sel(1'b1);
        chk("R4 stored", rx_valid, 1);
        chk("R2 reserved size 8-bit", rx_data, 9'h0C3);
        chk("R9 idle ones", got[7:0], 8'hFF);
        pop();
        char_sz = 3'd0;

        // R8 preload
        preload_en = 1'b1;
        write_tx(9'h03C);
        sel(1'b0);
        shift(9'h000, 8, got);
        sel(1'b1);
        chk("R8 preload", got[7:0], 8'h3C);
        pop();
        preload_en = 1'b0;

        // R9 load at first edge
        write_tx(9'h05A);
        sel(1'b0);
        shift(9'h011, 8, got);
        sel(1'b1);
        chk("R9 held load", got[7:0], 8'h5A);
        pop();

        // R5 overflow
        sel(1'b0);
        shift(9'h011, 8, got);
        shift(9'h022, 8, got);
        sel(1'b1);
        chk("R5 valid", rx_valid, 1);
        chk("R5 old kept", rx_data, 9'h011);
        chk("R5 ovf", rx_ovf, 1);
        wclk(5);
        chk("R5 ovf sticky", rx_ovf, 1);

        // R6 flush
        rx_en = 1'b0;
        wclk(1);
        chk("R6 valid cleared", rx_valid, 0);
        chk("R6 ovf cleared", rx_ovf, 0);
        rx_en = 1'b1;
        wclk(3);
        sel(1'b0);
        shift(9'h00F, 4, got);
        rx_en = 1'b0;
        wclk(2);
        rx_en = 1'b1;
        wclk(3);
        shift(9'h096, 8, got);
        sel(1'b1);
        chk("R6 partial discarded", rx_data, 9'h096);
        pop();

        // R10 select rise mid-character
        sel(1'b0);
        shift(9'h01F, 5, got);
        sel(1'b1);
        chk("R10 no store", rx_valid, 0);
        sel(1'b0);
        shift(9'h069, 8, got);
        sel(1'b1);
        chk("R10 realigned", rx_data, 9'h069);
        pop();

        // R11 wake
        begin
            int cnt;
            ss_wake_en = 1'b1;
            ss_n = 1'b0;
            cnt = 0;
            for (int i = 0; i < 8; i++) begin
                wclk(1);
                if (wake) cnt++;
            end
            chk("R11 one pulse", cnt, 1);
            sel(1'b1);
            ss_wake_en = 1'b0;
            ss_n = 1'b0;
            cnt = 0;
            for (int i = 0; i < 8; i++) begin
                wclk(1);
                if (wake) cnt++;
            end
            chk("R11 disabled", cnt, 0);
            sel(1'b1);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule